// File: doc/BRIEF.md
# External Interrupt Sensitivity Controller

This block turns fifteen general-purpose pins and one dedicated interrupt pin into five interrupt request lines. Each pin group can react to a rising edge, a falling edge, both edges, or an edge together with the matching level. The choice is set by an 8-bit control register. The pins feeding group 0 and group 2 also have an invert bit, which remaps their sensitivity code.

The control register has a plain write strobe and a combinational read-back. Its sensitivity and invert fields only accept writes while the processor runs at its highest interrupt level, which is 3. The dedicated pin has an enable bit. Its edge select only accepts writes while that enable is clear.

All pins pass through a two-flop synchronizer. Edges are found by comparing each synchronized value with its value on the previous clock. Each group's request is the registered OR of its per-pin events.

Top module: `extint_sense_ctrl`

## Requirements
- R1: While and after reset, `cfg_rd_data` reads 00h and all five request outputs are 0, provided every pin is held high.
- R2: `cfg_rd_data` always returns the eight stored register bits unchanged, and the register changes only on a clock edge with `cfg_wr_en` high.
- R3: Bits 7:2 (bits 7:6 group 2/3 code, bit 5 group 2 invert, bits 4:3 group 0/1 code, bit 2 group 0 invert) take a write only when `cpu_level` is 2'b11; otherwise they keep their value.
- R4: Bit 0 (dedicated pin enable) takes every write. Bit 1 (dedicated pin edge select) takes a write only if the stored bit 0 is 0 before that write.
- R5: While the stored bit 0 is 0, `irq_top` stays 0 whatever `pin_top` does.
- R6: With the invert bit 0, a code selects: 00 = low level (a falling edge included), 01 = rising edge, 10 = falling edge, 11 = both edges.
- R7: With the invert bit 1, a code selects: 00 = high level (a rising edge included), 01 = falling edge, 10 = rising edge, 11 = both edges.
- R8: The invert bits act only on group 0 (`pin_a`) and on group 2 (`pin_b[3:0]`). Group 1 (`pin_f`) and group 3 (`pin_b[7:4]`) always decode their code as if the invert bit were 0.
- R9: An edge event gives a one-cycle pulse. The pulse is visible after the third rising clock edge that follows the pin change, and is gone after the fourth.
- R10: In a level mode, a group's request stays high for as long as any pin of that group is at the active level. It falls three clock edges after the last such pin leaves that level.
- R11: With bit 0 set, bit 1 = 0 makes `irq_top` pulse on a falling edge of `pin_top`, and bit 1 = 1 makes it pulse on a rising edge. The other edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 8 | Control register write value |
| cfg_rd_data | output | 8 | Stored control register value |
| cpu_level | input | 2 | Current processor interrupt level |
| pin_a | input | 4 | Group 0 pins |
| pin_b | input | 8 | Group 2 pins (3:0) and group 3 pins (7:4) |
| pin_f | input | 3 | Group 1 pins |
| pin_top | input | 1 | Dedicated interrupt pin |
| irq_grp0 | output | 1 | Group 0 request |
| irq_grp1 | output | 1 | Group 1 request |
| irq_grp2 | output | 1 | Group 2 request |
| irq_grp3 | output | 1 | Group 3 request |
| irq_top | output | 1 | Dedicated pin request |

## Verification
The bench runs every code and invert combination in both edge directions. Groups with and without an invert bit are compared in the same run. A design that applied the invert bit to a whole port would show the wrong response on group 1 or group 3.

Directed tests cover several cases:
- Writes below level 3 are tried; a design without the lock would change the sensitivity fields.
- The edge select is written while the enable bit is set; a design without that lock would flip the sensitive edge.
- A level request is handed from one pin to another; a design that tracked only one pin would drop the request.
- The pulse is sampled one edge early and one edge late; a design with the wrong latency or a pulse width other than one cycle would fail these samples.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam int CFG_W     = 8;
  localparam int F_CODE_HI = 7;  // group 2/3 code, upper bit
  localparam int F_CODE_HL = 6;
  localparam int F_INV_HI  = 5;  // group 2 invert
  localparam int F_CODE_LH = 4;  // group 0/1 code, upper bit
  localparam int F_CODE_LL = 3;
  localparam int F_INV_LO  = 2;  // group 0 invert
  localparam int F_TOP_SEL = 1;  // dedicated pin edge select
  localparam int F_TOP_EN  = 0;  // dedicated pin enable
  localparam logic [1:0] LEVEL_MAX = 2'b11;

  typedef struct packed {
    logic rise;
    logic fall;
    logic lvl_hi;
    logic lvl_lo;
  } sense_t;

  function automatic sense_t decode_sense(input logic [1:0] code, input logic inv);
    sense_t m;
    m = '0;
    unique case (code)
      2'b00: begin
        m.lvl_lo = ~inv;
        m.lvl_hi = inv;
        m.fall   = ~inv;
        m.rise   = inv;
      end
      2'b01: begin
        m.rise = ~inv;
        m.fall = inv;
      end
      2'b10: begin
        m.fall = ~inv;
        m.rise = inv;
      end
      default: begin
        m.rise = 1'b1;
        m.fall = 1'b1;
      end
    endcase
    return m;
  endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int   W      = 4,
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{{W{IDLE}}}};
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/extint_cfg_reg.sv
module extint_cfg_reg
  import extint_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic [1:0]       cpu_level,
  output logic [CFG_W-1:0] cfg
);

  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;
  logic             lvl_ok;

  assign lvl_ok = (cpu_level == LEVEL_MAX);

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      if (lvl_ok) begin
        cfg_d[F_CODE_HI:F_INV_LO] = wr_data[F_CODE_HI:F_INV_LO];
      end
      if (!cfg_q[F_TOP_EN]) begin
        cfg_d[F_TOP_SEL] = wr_data[F_TOP_SEL];
      end
      cfg_d[F_TOP_EN] = wr_data[F_TOP_EN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  a_r3_level_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cpu_level != LEVEL_MAX) |=> $stable(cfg_q[F_CODE_HI:F_INV_LO]));

  a_r4_sel_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cfg_q[F_TOP_EN]) |=> $stable(cfg_q[F_TOP_SEL]));

  a_r4_en_free: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q[F_TOP_EN] == $past(wr_data[F_TOP_EN])));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/extint_group_det.sv
module extint_group_det
  import extint_pkg::*;
#(
  parameter int   W    = 4,
  parameter logic IDLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sense_t       mode,
  input  logic [W-1:0] cur,
  output logic         req
);

  logic [W-1:0] prev_q;
  logic [W-1:0] ev;
  logic         req_q;
  logic         edge_only_rise;

  assign edge_only_rise = mode.rise && !mode.fall && !mode.lvl_hi && !mode.lvl_lo;

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign ev[i] = (mode.rise   &  cur[i] & ~prev_q[i]) |
                   (mode.fall   & ~cur[i] &  prev_q[i]) |
                   (mode.lvl_hi &  cur[i])              |
                   (mode.lvl_lo & ~cur[i]);

    // R9: a rising-only pin event never repeats on the next cycle
    a_r9_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[i] && edge_only_rise) |=> (!ev[i] || (mode != $past(mode))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= {W{IDLE}};
      req_q  <= 1'b0;
    end else begin
      prev_q <= cur;
      req_q  <= |ev;
    end
  end

  assign req = req_q;

  a_r10_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.lvl_lo && !(&cur)) |=> req_q);

endmodule

// File: rtl/extint_sense_ctrl.sv
module extint_sense_ctrl
  import extint_pkg::*;
#(
  parameter int   A_W         = 4,
  parameter int   B_W         = 8,
  parameter int   F_W         = 3,
  parameter int   SYNC_STAGES = 2,
  parameter logic PIN_IDLE    = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  output logic [CFG_W-1:0] cfg_rd_data,
  input  logic [1:0]       cpu_level,
  input  logic [A_W-1:0]   pin_a,
  input  logic [B_W-1:0]   pin_b,
  input  logic [F_W-1:0]   pin_f,
  input  logic             pin_top,
  output logic             irq_grp0,
  output logic             irq_grp1,
  output logic             irq_grp2,
  output logic             irq_grp3,
  output logic             irq_top
);

  localparam int B_HALF = B_W / 2;
  localparam int ALL_W  = A_W + B_W + F_W + 1;

  logic [CFG_W-1:0] cfg;
  logic [ALL_W-1:0] pins_raw;
  logic [ALL_W-1:0] pins_s;
  logic [A_W-1:0]   a_s;
  logic [B_W-1:0]   b_s;
  logic [F_W-1:0]   f_s;
  logic             top_s;
  sense_t           mode_g0, mode_g1, mode_g2, mode_g3, mode_top;

  extint_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_data   (cfg_wr_data),
    .cpu_level (cpu_level),
    .cfg       (cfg)
  );

  assign cfg_rd_data = cfg;

  assign pins_raw = {pin_top, pin_f, pin_b, pin_a};

  extint_sync #(.W(ALL_W), .STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  assign a_s   = pins_s[A_W-1:0];
  assign b_s   = pins_s[A_W+B_W-1:A_W];
  assign f_s   = pins_s[A_W+B_W+F_W-1:A_W+B_W];
  assign top_s = pins_s[ALL_W-1];

  always_comb begin
    mode_g0  = decode_sense(cfg[F_CODE_LH:F_CODE_LL], cfg[F_INV_LO]);
    mode_g1  = decode_sense(cfg[F_CODE_LH:F_CODE_LL], 1'b0);
    mode_g2  = decode_sense(cfg[F_CODE_HI:F_CODE_HL], cfg[F_INV_HI]);
    mode_g3  = decode_sense(cfg[F_CODE_HI:F_CODE_HL], 1'b0);
    mode_top = '0;
    mode_top.rise = cfg[F_TOP_EN] &  cfg[F_TOP_SEL];
    mode_top.fall = cfg[F_TOP_EN] & ~cfg[F_TOP_SEL];
  end

  extint_group_det #(.W(A_W), .IDLE(PIN_IDLE)) u_det0 (
    .clk(clk), .rst_n(rst_n), .mode(mode_g0), .cur(a_s), .req(irq_grp0));

  extint_group_det #(.W(F_W), .IDLE(PIN_IDLE)) u_det1 (
    .clk(clk), .rst_n(rst_n), .mode(mode_g1), .cur(f_s), .req(irq_grp1));

  extint_group_det #(.W(B_HALF), .IDLE(PIN_IDLE)) u_det2 (
    .clk(clk), .rst_n(rst_n), .mode(mode_g2), .cur(b_s[B_HALF-1:0]), .req(irq_grp2));

  extint_group_det #(.W(B_W-B_HALF), .IDLE(PIN_IDLE)) u_det3 (
    .clk(clk), .rst_n(rst_n), .mode(mode_g3), .cur(b_s[B_W-1:B_HALF]), .req(irq_grp3));

  extint_group_det #(.W(1), .IDLE(PIN_IDLE)) u_dettop (
    .clk(clk), .rst_n(rst_n), .mode(mode_top), .cur(top_s), .req(irq_top));

  a_r5_top_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[F_TOP_EN] |=> !irq_top);

endmodule

// File: tb/extint_sense_ctrl_tb.sv
module extint_sense_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  // [7:6] code, [5] invert, [4] new pin value, [3] inverted-group now,
  // [2] inverted-group next, [1] plain-group now, [0] plain-group next
  localparam logic [7:0] VEC [16] = '{
    8'b00_0_1_0000, 8'b00_0_0_1111, 8'b01_0_1_1010, 8'b01_0_0_0000,
    8'b10_0_1_0000, 8'b10_0_0_1010, 8'b11_0_1_1010, 8'b11_0_0_1010,
    8'b00_1_1_1100, 8'b00_1_0_0011, 8'b01_1_1_0010, 8'b01_1_0_1000,
    8'b10_1_1_1000, 8'b10_1_0_0010, 8'b11_1_1_1010, 8'b11_1_0_1010
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = '0;
  logic [7:0] cfg_rd_data;
  logic [1:0] cpu_level = 2'b00;
  logic [3:0] pin_a = '1;
  logic [7:0] pin_b = '1;
  logic [2:0] pin_f = '1;
  logic       pin_top = 1'b1;
  logic       irq_grp0, irq_grp1, irq_grp2, irq_grp3, irq_top;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extint_sense_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .cpu_level(cpu_level), .pin_a(pin_a), .pin_b(pin_b),
    .pin_f(pin_f), .pin_top(pin_top), .irq_grp0(irq_grp0), .irq_grp1(irq_grp1),
    .irq_grp2(irq_grp2), .irq_grp3(irq_grp3), .irq_top(irq_top));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic write_cfg(input logic [7:0] val, input logic [1:0] lvl);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = val; cpu_level = lvl;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic set_groups(input logic v);
    pin_a = {4{v}}; pin_b = {8{v}}; pin_f = {3{v}};
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 rd in reset", cfg_rd_data, 8'h00);
    chk("R1 irqs in reset", {3'b0, irq_grp0, irq_grp1, irq_grp2, irq_grp3, irq_top}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 rd after reset", cfg_rd_data, 8'h00);
    chk("R1 irqs after reset", {3'b0, irq_grp0, irq_grp1, irq_grp2, irq_grp3, irq_top}, 8'h00);

    // Table: every code, invert and edge direction
    for (int i = 0; i < 16; i++) begin
      automatic logic [7:0] v = VEC[i];
      write_cfg({v[7:6], v[5], v[7:6], v[5], 2'b00}, 2'b11);
      set_groups(~v[4]);
      repeat (5) @(negedge clk);
      set_groups(v[4]);
      repeat (3) @(posedge clk);
      #1;
      chk($sformatf("R6 R7 g0 now v%0d", i), {7'b0, irq_grp0}, {7'b0, v[3]});
      chk($sformatf("R7 g2 now v%0d", i), {7'b0, irq_grp2}, {7'b0, v[3]});
      chk($sformatf("R8 g1 now v%0d", i), {7'b0, irq_grp1}, {7'b0, v[1]});
      chk($sformatf("R8 g3 now v%0d", i), {7'b0, irq_grp3}, {7'b0, v[1]});
      @(posedge clk);
      #1;
      chk($sformatf("R9 g0 next v%0d", i), {7'b0, irq_grp0}, {7'b0, v[2]});
      chk($sformatf("R9 g2 next v%0d", i), {7'b0, irq_grp2}, {7'b0, v[2]});
      chk($sformatf("R10 g1 next v%0d", i), {7'b0, irq_grp1}, {7'b0, v[0]});
      chk($sformatf("R10 g3 next v%0d", i), {7'b0, irq_grp3}, {7'b0, v[0]});
    end
    set_groups(1'b1);
    write_cfg(8'h00, 2'b11);
    repeat (5) @(negedge clk);

    // R2 R3 R4 register write rules
    write_cfg(8'hFF, 2'b11);
    chk("R2 full write", cfg_rd_data, 8'hFF);
    write_cfg(8'h00, 2'b10);
    chk("R3 level 2 locks fields, R4 sel locked", cfg_rd_data, 8'hFE);
    write_cfg(8'h01, 2'b00);
    chk("R3 level 0 locks fields, R4 sel free", cfg_rd_data, 8'hFD);
    write_cfg(8'h02, 2'b11);
    chk("R4 sel locked while enabled", cfg_rd_data, 8'h00);
    write_cfg(8'hA8, 2'b01);
    chk("R3 level 1 ignored", cfg_rd_data, 8'h00);
    repeat (4) @(negedge clk);
    chk("R2 stable without write", cfg_rd_data, 8'h00);

    // R11 R9 dedicated pin, falling edge
    write_cfg(8'h01, 2'b00);
    chk("R4 enable free", cfg_rd_data, 8'h01);
    pin_top = 1'b0;
    repeat (2) @(posedge clk); #1;
    chk("R9 not before third edge", {7'b0, irq_top}, 8'h00);
    @(posedge clk); #1;
    chk("R11 falling pulse", {7'b0, irq_top}, 8'h01);
    @(posedge clk); #1;
    chk("R9 pulse one cycle", {7'b0, irq_top}, 8'h00);
    @(negedge clk); pin_top = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk("R11 rising ignored", {7'b0, irq_top}, 8'h00);
    @(posedge clk); #1;
    chk("R11 rising ignored next", {7'b0, irq_top}, 8'h00);

    // R11 rising edge
    write_cfg(8'h00, 2'b00);
    write_cfg(8'h03, 2'b00);
    chk("R4 sel written while disabled", cfg_rd_data, 8'h03);
    pin_top = 1'b0;
    repeat (3) @(posedge clk); #1;
    chk("R11 falling ignored", {7'b0, irq_top}, 8'h00);
    repeat (3) @(negedge clk);
    pin_top = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk("R11 rising pulse", {7'b0, irq_top}, 8'h01);

    // R5 disabled
    write_cfg(8'h02, 2'b11);
    chk("R4 sel kept on disable", cfg_rd_data, 8'h02);
    pin_top = 1'b0;
    repeat (3) @(posedge clk); #1;
    chk("R5 off fall", {7'b0, irq_top}, 8'h00);
    @(negedge clk); pin_top = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk("R5 off rise", {7'b0, irq_top}, 8'h00);
    @(posedge clk); #1;
    chk("R5 off rise next", {7'b0, irq_top}, 8'h00);

    // R10 level hand-over between pins
    write_cfg(8'h00, 2'b11);
    repeat (5) @(negedge clk);
    pin_a = 4'b1011;
    repeat (3) @(posedge clk); #1;
    chk("R10 level asserted", {7'b0, irq_grp0}, 8'h01);
    repeat (5) @(posedge clk); #1;
    chk("R10 level held", {7'b0, irq_grp0}, 8'h01);
    @(negedge clk); pin_a = 4'b1101;
    repeat (4) @(posedge clk); #1;
    chk("R10 other pin keeps level", {7'b0, irq_grp0}, 8'h01);
    chk("R10 group 1 idle", {7'b0, irq_grp1}, 8'h00);
    @(negedge clk); pin_a = 4'hF;
    repeat (2) @(posedge clk); #1;
    chk("R10 still high before third edge", {7'b0, irq_grp0}, 8'h01);
    @(posedge clk); #1;
    chk("R10 released", {7'b0, irq_grp0}, 8'h00);

    // R9 OR of pins in group 3, rising mode
    write_cfg(8'h40, 2'b11);
    @(negedge clk); pin_b = 8'h00;
    repeat (5) @(negedge clk);
    pin_b = 8'h40;
    repeat (3) @(posedge clk); #1;
    chk("R9 group 3 single pin", {7'b0, irq_grp3}, 8'h01);
    chk("R8 group 2 untouched", {7'b0, irq_grp2}, 8'h00);
    @(posedge clk); #1;
    chk("R9 group 3 pulse ends", {7'b0, irq_grp3}, 8'h00);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule